// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block drives a two-wire I2C bus one primitive at a time. Software writes a 3-bit operation selector. It then pulses a go strobe to launch a single bus action: a start condition, a stop condition, an outgoing byte, an incoming byte, an acknowledge bit, a not-acknowledge bit, or the sampling of the target's acknowledge bit. Complete transfers are built by software as a chain of these commands. While an action runs, the block shows busy. When the action ends, busy drops and the interrupt flag rises on the same clock edge. A 3-bit result code then tells software which action finished.

Both bus lines are open drain. The block pulls a line low by asserting its output enable and releases it otherwise. The data line is read back through its own input. Bit timing comes from a programmable divider. Every bit period is split into four equal quarter-phases, and the data line only moves while the clock line is held low, except inside start and stop. The outgoing byte, the incoming byte and all control values are plain register ports. There is no streaming interface and no back-pressure: a byte is taken from the transmit port at launch, and the received byte is held until the next receive completes.

Top module: `i2c_cmd_master`

## Requirements
- R1: The selector register `op_sel` resets to 0 and loads `cmd_op` whenever `cmd_wr` is 1. A `cmd_go` in the same cycle as `cmd_wr` uses the newly written value. Codes: 0 start, 1 stop, 2 send byte, 3 receive byte, 4 send ACK, 5 send NAK, 6 receive ACK/NAK, 7 reserved.
- R2: A `cmd_go` while idle with a code other than 7 makes `busy` read 1 from the next clock cycle on.
- R3: When the action ends, `busy` falls and `irq` rises on the same edge. `status` becomes 0 after start, 1 after stop, 2 after a sent byte, 3 after a received byte, 4 after an ACK or NAK was sent, 5 when ACK (line low) was read, and 6 when NAK (line high) was read.
- R4: A 1 on `irq_clr` clears `irq` and returns `status` to 0. If an action completes in that same cycle, the completion wins, and `irq` and the new `status` remain set.
- R5: A `cmd_go` while `busy` is 1 does not alter the running action or its result. A `cmd_go` with code 7 starts nothing and leaves `busy`, `irq` and `status` untouched.
- R6: Start pulls SDA low while SCL is high, and leaves SCL held low. Stop releases SDA while SCL is high, and leaves both lines released.
- R7: A sent byte goes out most significant bit first, one bit per SCL high pulse. SDA changes only while SCL is held low.
- R8: A received byte is sampled most significant bit first while SCL is high. It appears on `rx_byte` in the same cycle that `status` becomes 3.
- R9: Send ACK drives SDA low, and send NAK releases SDA, for one SCL pulse. Both report status 4.
- R10: Receive ACK/NAK releases SDA for one SCL pulse and samples it while SCL is high. A low level gives status 5 and a high level gives status 6.
- R11: Each quarter-phase lasts `clk_div`+1 clock cycles, so an SCL high pulse lasts 2*(`clk_div`+1) cycles.
- R12: After reset, `busy`, `irq`, `status` and both output enables are 0, so both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the operation selector |
| cmd_op | input | 3 | Operation code to write |
| cmd_go | input | 1 | Launch strobe (write of 1 to the trigger) |
| op_sel | output | 3 | Current operation selector |
| tx_byte | input | 8 | Byte to send, taken at launch |
| rx_byte | output | 8 | Last received byte |
| busy | output | 1 | An action is running |
| irq | output | 1 | Completion flag |
| irq_clr | input | 1 | Write-1 clear of the completion flag and status |
| status | output | 3 | Completion code |
| clk_div | input | DIV_W | Quarter-phase length minus one, in clock cycles |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The two functions that can land in the same cycle are the software clear of the completion flag and the setting of that flag by a finishing action. The bench provokes this by holding `irq_clr` at 1 for the whole run of a byte receive and of an ACK/NAK receive. At the sample where `busy` first reads 0, `irq` must be 1 and `status` must hold the fresh code. One cycle later, the clear that is still applied must have returned both to 0.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_STOP = 3'd1, OP_TX = 3'd2, OP_RX = 3'd3,
    OP_ACK = 3'd4, OP_NAK = 3'd5, OP_ACKRX = 3'd6, OP_RSVD = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_START = 3'd0, ST_STOP = 3'd1, ST_TXDONE = 3'd2, ST_RXDONE = 3'd3,
    ST_ACKSENT = 3'd4, ST_ACKGOT = 3'd5, ST_NAKGOT = 3'd6
  } stat_e;

  typedef enum logic [1:0] {
    SYM_START = 2'd0, SYM_STOP = 2'd1, SYM_BIT = 2'd2
  } sym_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R11
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/i2cm_symbol.sv
module i2cm_symbol
  import i2cm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  sym_e kind,
  input  logic bitv,
  input  logic tick,
  input  logic sda_in,
  output logic run,
  output logic scl_oe,
  output logic sda_oe,
  output logic sample,
  output logic done
);
  logic [1:0] q;
  sym_e       kind_q;
  logic       bit_q;

  function automatic logic [1:0] drive(sym_e k, logic [1:0] ph, logic b);
    logic [1:0] r;
    case (k)
      SYM_START: case (ph)
        2'd0: r = 2'b10;
        2'd1: r = 2'b00;
        2'd2: r = 2'b01;
        default: r = 2'b11;
      endcase
      SYM_STOP: case (ph)
        2'd0: r = 2'b11;
        2'd1: r = 2'b01;
        default: r = 2'b00;
      endcase
      default: r = {(ph == 2'd0) || (ph == 2'd3), ~b};
    endcase
    return r;
  endfunction

  assign done = run && tick && (q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      q      <= 2'd0;
      kind_q <= SYM_BIT;
      bit_q  <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      sample <= 1'b1;
    end else if (go && !run) begin
      run    <= 1'b1;
      q      <= 2'd0;
      kind_q <= kind;
      bit_q  <= bitv;
    end else if (run && tick) begin
      {scl_oe, sda_oe} <= drive(kind_q, q, bit_q);
      if (q == 2'd2) sample <= sda_in;
      if (q == 2'd3) run <= 1'b0;
      q <= q + 2'd1;
    end
  end

  // R7
  sda_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(sda_oe) && kind_q == SYM_BIT) |-> scl_oe);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_go,
  output logic [2:0]       op_sel,
  input  logic [7:0]       tx_byte,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             irq,
  input  logic             irq_clr,
  output logic [2:0]       status,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

  logic [2:0]        op_eff;
  op_e               op_act;
  logic [2:0]        bits_left;
  logic [BYTE_W-1:0] shreg;
  logic              sym_go, sym_run, sym_done, sym_sample, tick;
  logic              launch, fin, bitv;
  sym_e              kind;
  logic [2:0]        code;

  assign op_eff = cmd_wr ? cmd_op : op_sel;
  assign launch = cmd_go && !busy && (op_eff != OP_RSVD);
  assign fin    = sym_done && (bits_left == 3'd0);

  always_comb begin
    kind = SYM_BIT;
    bitv = 1'b1;
    code = ST_START;
    case (op_act)
      OP_START: begin kind = SYM_START; code = ST_START; end
      OP_STOP:  begin kind = SYM_STOP;  code = ST_STOP;  end
      OP_TX:    begin bitv = shreg[BYTE_W-1]; code = ST_TXDONE; end
      OP_RX:    code = ST_RXDONE;
      OP_ACK:   begin bitv = 1'b0; code = ST_ACKSENT; end
      OP_NAK:   code = ST_ACKSENT;
      default:  code = sym_sample ? ST_NAKGOT : ST_ACKGOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_sel <= OP_START;
    else if (cmd_wr) op_sel <= cmd_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_act    <= OP_START;
      bits_left <= 3'd0;
      shreg     <= '0;
      sym_go    <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sym_go <= 1'b0;
      if (launch) begin
        busy      <= 1'b1;
        op_act    <= op_e'(op_eff);
        sym_go    <= 1'b1;
        shreg     <= tx_byte;
        bits_left <= (op_eff == OP_TX || op_eff == OP_RX) ? LAST_BIT : 3'd0;
      end else if (sym_done) begin
        if (bits_left != 3'd0) begin
          bits_left <= bits_left - 3'd1;
          shreg     <= {shreg[BYTE_W-2:0], sym_sample};
          sym_go    <= 1'b1;
        end else begin
          busy <= 1'b0;
          if (op_act == OP_RX) rx_byte <= {shreg[BYTE_W-2:0], sym_sample};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      status <= ST_START;
    end else if (fin) begin
      irq    <= 1'b1;
      status <= code;
    end else if (irq_clr) begin
      irq    <= 1'b0;
      status <= ST_START;
    end
  end

  i2cm_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(sym_run), .div(clk_div), .tick(tick)
  );

  i2cm_symbol u_sym (
    .clk(clk), .rst_n(rst_n), .go(sym_go), .kind(kind), .bitv(bitv),
    .tick(tick), .sda_in(sda_in), .run(sym_run), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sample(sym_sample), .done(sym_done)
  );

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && op_eff != OP_RSVD) |=> busy);
  // R3
  busy_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  // R4
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fin) |=> (!irq && status == 3'd0));
  // R5
  rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && op_eff == OP_RSVD) |=> !busy);
endmodule

// File: tb/sim_i2c_cmd_master.sv
`timescale 1ns/1ps
module sim_i2c_cmd_master;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_go = 0, irq_clr = 0;
  logic [2:0] cmd_op = 0;
  logic [7:0] tx_byte = 0;
  logic [DIV_W-1:0] clk_div = 8'd3;
  logic [2:0] op_sel, status;
  logic [7:0] rx_byte;
  logic busy, irq, scl_oe, sda_oe;

  logic tgt_en = 0;
  logic [7:0] tgt_byte = 8'hFF;
  logic [2:0] tgt_falls = 0;
  wire tgt_pull = tgt_en && !tgt_byte[3'd7 - tgt_falls];
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || tgt_pull);

  int checks = 0, errors = 0;
  int starts = 0, stops = 0, hi_run = 0, hi_len = 0;
  logic [7:0] mon = 0;

  always #10 clk = !clk;

  i2c_cmd_master #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_go(cmd_go),
    .op_sel(op_sel), .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy), .irq(irq),
    .irq_clr(irq_clr), .status(status), .clk_div(clk_div), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge sda_line) if (rst_n && scl_line === 1'b1) starts++;
  always @(posedge sda_line) if (rst_n && scl_line === 1'b1) stops++;
  always @(posedge scl_line) mon = {mon[6:0], sda_line};
  always @(negedge scl_line) if (tgt_en) tgt_falls = tgt_falls + 3'd1;
  always @(negedge clk) begin
    if (scl_line === 1'b1) hi_run++;
    else if (hi_run != 0) begin hi_len = hi_run; hi_run = 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [2:0] op);
    @(negedge clk);
    cmd_wr = 1; cmd_op = op; cmd_go = 1;
    @(negedge clk);
    cmd_wr = 0; cmd_go = 0;
    chk(busy == 1'b1, "R2 busy after launch", busy, 1);
    wait_idle();
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(irq == 1'b0 && status == 3'd0, "R4 clear", {irq, status}, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && irq == 0 && status == 0, "R12 flags", {busy, irq, status}, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R12 lines released", {scl_oe, sda_oe}, 0);
    chk(op_sel == 3'd0, "R1 selector reset", op_sel, 0);
  endtask

  task automatic t_start();
    int s0 = starts;
    run_cmd(3'd0);
    chk(starts == s0 + 1, "R6 start seen", starts - s0, 1);
    chk(scl_line == 1'b0, "R6 scl held low", scl_line, 0);
    chk(irq == 1 && status == 3'd0, "R3 start status", {irq, status}, 8);
    clear_irq();
  endtask

  task automatic t_tx(input logic [7:0] b, input logic [DIV_W-1:0] d, input bit poke);
    int s0 = starts, p0 = stops;
    clk_div = d; tx_byte = b;
    @(negedge clk); cmd_wr = 1; cmd_op = 3'd2; cmd_go = 1;
    @(negedge clk); cmd_wr = 0; cmd_go = 0;
    if (poke) begin
      repeat (12) @(negedge clk);
      cmd_wr = 1; cmd_op = 3'd1; cmd_go = 1;
      @(negedge clk); cmd_wr = 0; cmd_go = 0;
      chk(op_sel == 3'd1, "R1 selector written", op_sel, 1);
    end
    wait_idle();
    chk(mon == b, "R7 byte msb first", mon, b);
    chk(starts == s0 && stops == p0, "R7 no sda change while scl high", starts + stops - s0 - p0, 0);
    chk(status == 3'd2 && irq, "R3 tx status", status, 2);
    chk(hi_len == 2 * (int'(d) + 1), "R11 scl high length", hi_len, 2 * (int'(d) + 1));
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy == 0 && status == 3'd2, "R5 busy trigger ignored", {busy, status}, 2);
    end
    clear_irq();
  endtask

  task automatic t_rx(input logic [7:0] b);
    tgt_byte = b; tgt_falls = 0; tgt_en = 1;
    run_cmd(3'd3);
    tgt_en = 0;
    chk(status == 3'd3 && rx_byte == b, "R8 rx byte", rx_byte, b);
    clear_irq();
  endtask

  task automatic t_ack_send(input logic [2:0] op, input logic lvl);
    run_cmd(op);
    chk(mon[0] == lvl, "R9 ack level on bus", mon[0], lvl);
    chk(status == 3'd4, "R9 ack sent status", status, 4);
    clear_irq();
  endtask

  task automatic t_ack_rx(input logic lvl);
    tgt_byte = {lvl, 7'h7F}; tgt_falls = 0; tgt_en = 1;
    run_cmd(3'd6);
    tgt_en = 0;
    chk(status == (lvl ? 3'd6 : 3'd5), "R10 ack receive status", status, lvl ? 6 : 5);
    clear_irq();
  endtask

  task automatic t_rsvd();
    @(negedge clk); cmd_wr = 1; cmd_op = 3'd7; cmd_go = 1;
    @(negedge clk); cmd_wr = 0; cmd_go = 0;
    repeat (30) @(negedge clk);
    chk(busy == 0 && irq == 0 && status == 0, "R5 reserved code", {busy, irq, status}, 0);
  endtask

  task automatic t_collide(input logic [2:0] op, input logic [2:0] exp_st);
    tgt_byte = 8'h00; tgt_falls = 0; tgt_en = 1;
    @(negedge clk); cmd_wr = 1; cmd_op = op; cmd_go = 1; irq_clr = 1;
    @(negedge clk); cmd_wr = 0; cmd_go = 0;
    wait_idle();
    chk(irq == 1 && status == exp_st, "R4 completion beats clear", {irq, status}, {1'b1, exp_st});
    @(negedge clk);
    chk(irq == 0 && status == 0, "R4 clear after completion", {irq, status}, 0);
    irq_clr = 0; tgt_en = 0;
  endtask

  task automatic t_stop();
    int p0 = stops;
    run_cmd(3'd1);
    chk(stops == p0 + 1, "R6 stop seen", stops - p0, 1);
    chk(scl_line && sda_line, "R6 lines idle", {scl_line, sda_line}, 3);
    chk(status == 3'd1, "R3 stop status", status, 1);
    clear_irq();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    starts = 0; stops = 0;
    t_start();
    t_tx(8'hA5, 8'd3, 1'b1);
    t_rx(8'h3C);
    t_ack_send(3'd4, 1'b0);
    t_ack_send(3'd5, 1'b1);
    t_ack_rx(1'b0);
    t_ack_rx(1'b1);
    t_rsvd();
    t_collide(3'd3, 3'd3);
    t_collide(3'd6, 3'd5);
    t_tx(8'h5A, 8'd0, 1'b0);
    t_rx(8'hC3);
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule